// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block sends a stereo pair of 24-bit two's complement samples over one serial data line, most significant bit first. Each frame has two halves, one per channel. The data line changes only on falling edges of the bit clock. A 2-bit format input selects one of four framings. Two of them are slave framings, in which the bit clock, the word clock and the frame strobe come from outside. The other two are master framings, in which the block drives those three pins itself.

A host loads the left and right words in parallel with a one-cycle strobe. The words go into a shadow pair, and a half frame only copies from that pair at its first slot. In master framing the block advances its bit clock on each pulse of a tick input, which comes from a separate divider. A speed-class input selects 64 bit slots per half frame (normal) or 32 (fast).

In slave framing the incoming pins pass through a synchronizer of `SYNC_STAGES` flops. The serial output is then registered once more, so each level of the external bit clock must last at least `SYNC_STAGES + 2` system clock cycles.

Top module: `aud_serial_tx`

## Requirements
- R1: In master framing, each half frame sends its word MSB first. Slot j (j = 1..24) carries bit 24-j of the word, and the data line changes only in the cycle the bit-clock output falls.
- R2: Format code fmt = {fmt[1], fmt[0]}. fmt[0]=1 is master: all three clock/strobe output enables are high. fmt[0]=0 is slave: the enables are low. fmt[1]=0 selects left on word clock high and right on low (codes 00 and 01). fmt[1]=1 selects left on word clock low (codes 10 and 11).
- R3: In slave framing 00, a word-clock edge puts the MSB of the new word on the data line. This holds even when the edge arrives together with a bit-clock falling edge.
- R4: In slave framing 10, the data line is 0 for the first bit period after a word-clock edge, and the MSB follows at the next bit-clock fall. The frame-sync input has no effect.
- R5: In slave framing 00, a bit-clock falling edge moves to the next bit only if frame sync was high during the bit period that edge ends. Otherwise the current bit is held.
- R6: In master framing, the word clock toggles only on bit-clock falls. A half frame lasts 64 bit periods when speed_fast=0 and 32 when speed_fast=1. The bit clock toggles on each mclk_tick pulse.
- R7: In master framing, the frame-sync output is high for bit slots 1 to 24 of each half frame and low in every other slot.
- R8: While rst_n is low, the bit-clock, word-clock, frame-sync and data outputs are all low.
- R9: The data line is 0 in the slot before the MSB in the delayed framings, and from the slot after the LSB until the next word starts.
- R10: A load strobe during a half frame does not change the word being sent. The next half frame sends the new word. A load that lands in the same cycle as a half-frame start is sent in that half.
- R11: In slave framing, every word-clock edge restarts the bit position. A half frame cut short by an early edge is followed by a correct half frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Framing code (R2) |
| speed_fast | input | 1 | Master half-frame length: 0 = 64 slots, 1 = 32 slots |
| mclk_tick | input | 1 | Master bit-clock toggle strobe from the divider |
| load | input | 1 | Capture left_word/right_word into the shadow pair |
| left_word | input | SAMPLE_W | Left sample, two's complement |
| right_word | input | SAMPLE_W | Right sample, two's complement |
| bclk_in | input | 1 | Bit clock in slave framing |
| wclk_in | input | 1 | Word clock in slave framing |
| fsync_in | input | 1 | Frame-sync gate in slave framing |
| bclk_out | output | 1 | Bit clock driven in master framing |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| wclk_out | output | 1 | Word clock driven in master framing |
| wclk_oe | output | 1 | Output enable for the word-clock pin |
| fsync_out | output | 1 | Frame strobe driven in master framing |
| fsync_oe | output | 1 | Output enable for the frame-strobe pin |
| sdata | output | 1 | Serial data |

## Verification
Two pairs of events can fall in the same cycle. In slave framing 00 the bench moves the word clock and the bit clock low at the same instant, so the start-of-half and the advance requests arrive together. The bench then expects the MSB, not the second bit. In master framing the bench watches the bit position and drives the load strobe so that it is sampled at the very edge that opens a half frame. It then expects the freshly loaded word across that whole half, while a load made mid-half must leave the running half untouched.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        FMT_SLV_JUST = 2'b00,
        FMT_MST_HI   = 2'b01,
        FMT_SLV_I2S  = 2'b10,
        FMT_MST_I2S  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic fsync;
        logic wclk;
        logic bclk;
    } pins_t;

    function automatic logic fmt_is_master(input logic [1:0] f);
        return f[0];
    endfunction

    // Word-clock level that carries the left channel
    function automatic logic fmt_left_level(input logic [1:0] f);
        return ~f[1];
    endfunction

    // One empty slot between the half-frame start and the MSB
    function automatic logic fmt_delayed(input logic [1:0] f);
        return f != FMT_SLV_JUST;
    endfunction

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/aud_tx_mclk.sv
module aud_tx_mclk #(
    parameter int HALF_NORM = 64,
    parameter int HALF_FAST = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic fast,
    output logic bclk,
    output logic wclk,
    output logic fall,
    output logic wedge,
    output logic wnext
);

    localparam int CW = $clog2(HALF_NORM);
    localparam logic [CW-1:0] LAST_N = CW'(HALF_NORM - 1);
    localparam logic [CW-1:0] LAST_F = CW'(HALF_FAST - 1);

    typedef struct packed {
        logic          bclk;
        logic          wclk;
        logic [CW-1:0] slot;
    } mst_t;

    mst_t          st_d, st_q;
    logic [CW-1:0] last_slot;

    always_comb begin
        last_slot = fast ? LAST_F : LAST_N;
        fall      = en & tick & st_q.bclk;
        wedge     = fall & (st_q.slot >= last_slot);
        st_d      = st_q;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            st_d.bclk = ~st_q.bclk;
            if (fall) begin
                if (wedge) begin
                    st_d.slot = '0;
                    st_d.wclk = ~st_q.wclk;
                end else begin
                    st_d.slot = st_q.slot + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk  = st_q.bclk;
    assign wclk  = st_q.wclk;
    assign wnext = ~st_q.wclk;

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] left_in,
    input  logic [W-1:0] right_in,
    input  logic         start,
    input  logic         start_lvl,
    input  logic         left_lvl,
    input  logic         delay,
    input  logic         adv,
    output logic         sdata,
    output logic         active
);

    localparam int KW = $clog2(W + 1);
    localparam logic [KW-1:0] KDONE = KW'(W);

    typedef struct packed {
        logic [W-1:0]  sh_l;
        logic [W-1:0]  sh_r;
        logic [W-1:0]  word;
        logic [KW-1:0] k;
        logic          pre;
        logic          sdata;
        logic          active;
    } sh_t;

    localparam sh_t SH_RESET = '{sh_l: '0, sh_r: '0, word: '0, k: KDONE,
                                 pre: 1'b0, sdata: 1'b0, active: 1'b0};

    sh_t          sh_d, sh_q;
    logic [W-1:0] next_l, next_r;

    always_comb begin
        next_l    = load ? left_in  : sh_q.sh_l;
        next_r    = load ? right_in : sh_q.sh_r;
        sh_d      = sh_q;
        sh_d.sh_l = next_l;
        sh_d.sh_r = next_r;
        if (start) begin
            // a load in the same cycle reaches the half that starts now
            sh_d.word = (start_lvl == left_lvl) ? next_l : next_r;
            sh_d.k    = '0;
            sh_d.pre  = delay;
        end else if (adv) begin
            if (sh_q.pre) begin
                sh_d.pre = 1'b0;
            end else if (sh_q.k != KDONE) begin
                sh_d.k    = sh_q.k + KW'(1);
                sh_d.word = {sh_q.word[W-2:0], 1'b0};
            end
        end
        sh_d.active = !sh_d.pre && (sh_d.k != KDONE);
        sh_d.sdata  = sh_d.active & sh_d.word[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= SH_RESET;
        else        sh_q <= sh_d;
    end

    assign sdata  = sh_q.sdata;
    assign active = sh_q.active;

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int HALF_NORM   = 64,
    parameter int HALF_FAST   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic                speed_fast,
    input  logic                mclk_tick,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    input  logic                bclk_in,
    input  logic                wclk_in,
    input  logic                fsync_in,
    output logic                bclk_out,
    output logic                bclk_oe,
    output logic                wclk_out,
    output logic                wclk_oe,
    output logic                fsync_out,
    output logic                fsync_oe,
    output logic                sdata
);

    localparam int PINS_W = $bits(pins_t);

    pins_t raw_pins, syn_pins;
    pins_t prev_d, prev_q;

    logic is_master;
    logic s_fall, s_wedge;
    logic m_bclk, m_wclk, m_fall, m_wedge, m_wnext;
    logic start, start_lvl, adv;
    logic sh_active;

    assign raw_pins  = '{fsync: fsync_in, wclk: wclk_in, bclk: bclk_in};
    assign is_master = fmt_is_master(fmt);

    aud_tx_sync #(
        .WIDTH  (PINS_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_pins),
        .dout  (syn_pins)
    );

    aud_tx_mclk #(
        .HALF_NORM (HALF_NORM),
        .HALF_FAST (HALF_FAST)
    ) i_mclk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (is_master),
        .tick  (mclk_tick),
        .fast  (speed_fast),
        .bclk  (m_bclk),
        .wclk  (m_wclk),
        .fall  (m_fall),
        .wedge (m_wedge),
        .wnext (m_wnext)
    );

    always_comb begin
        prev_d  = syn_pins;
        s_fall  = !is_master && prev_q.bclk && !syn_pins.bclk;
        s_wedge = !is_master && (prev_q.wclk != syn_pins.wclk);
        if (is_master) begin
            start     = m_wedge;
            start_lvl = m_wnext;
            adv       = m_fall;
        end else begin
            start     = s_wedge;
            start_lvl = syn_pins.wclk;
            // framing 00: advance only if the strobe was high in the bit just ended
            adv       = s_fall && (fmt[1] || prev_q.fsync);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    aud_tx_shift #(
        .W (SAMPLE_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .left_in   (left_word),
        .right_in  (right_word),
        .start     (start),
        .start_lvl (start_lvl),
        .left_lvl  (fmt_left_level(fmt)),
        .delay     (fmt_delayed(fmt)),
        .adv       (adv),
        .sdata     (sdata),
        .active    (sh_active)
    );

    assign bclk_out  = m_bclk;
    assign wclk_out  = m_wclk;
    assign fsync_out = is_master & sh_active;
    assign bclk_oe   = is_master;
    assign wclk_oe   = is_master;
    assign fsync_oe  = is_master;

endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fmt,
    input logic       bclk_out,
    input logic       wclk_out,
    input logic       fsync_out,
    input logic       sdata
);

    logic mst;
    assign mst = fmt[0];

    // R8
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!bclk_out && !wclk_out && !fsync_out && !sdata));

    // R6
    wclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst && $past(mst) && $changed(wclk_out) |-> $fell(bclk_out));

    // R7
    fsync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst && $past(mst) && $changed(fsync_out) |-> $fell(bclk_out));

    // R1
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst && $past(mst) && $changed(sdata) |-> $fell(bclk_out));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst && !fsync_out |-> !sdata);

endmodule

bind aud_serial_tx aud_serial_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .bclk_out  (bclk_out),
    .wclk_out  (wclk_out),
    .fsync_out (fsync_out),
    .sdata     (sdata)
);

// File: tb/test_aud_serial_tx.sv
module test_aud_serial_tx;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   fmt = 2'b00;
    logic         speed_fast = 1'b0;
    logic         mclk_tick = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] lw = '0, rw = '0;
    logic         bclk_in = 1'b1, wclk_in = 1'b0, fsync_in = 1'b0;
    logic         bclk_out, bclk_oe, wclk_out, wclk_oe, fsync_out, fsync_oe, sdata;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [W-1:0] sh_l = '0, sh_r = '0, cur_word = '0;
    logic         mon_en = 1'b0, prev_b = 1'b0, prev_w = 1'b0, seen_half = 1'b0;
    int           halves = 0, j = 0, per = 0, half_len = 64;

    always #2 clk = ~clk;

    aud_serial_tx i_aud_serial_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .speed_fast (speed_fast),
        .mclk_tick  (mclk_tick),
        .load       (load),
        .left_word  (lw),
        .right_word (rw),
        .bclk_in    (bclk_in),
        .wclk_in    (wclk_in),
        .fsync_in   (fsync_in),
        .bclk_out   (bclk_out),
        .bclk_oe    (bclk_oe),
        .wclk_out   (wclk_out),
        .wclk_oe    (wclk_oe),
        .fsync_out  (fsync_out),
        .fsync_oe   (fsync_oe),
        .sdata      (sdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // one system cycle; master-framing monitor runs at each falling clk edge
    task automatic step();
        logic  fell, exp_f, exp_d;
        string tag;
        @(negedge clk);
        if (mon_en) begin
            fell = prev_b && !bclk_out;
            if (wclk_out != prev_w && !fell)
                chk(1'b0, "R6", {31'd0, wclk_out}, {31'd0, prev_w});
            if (fell) begin
                if (wclk_out != prev_w) begin
                    if (seen_half) chk(per == half_len, "R6", per, half_len);
                    seen_half = 1'b1;
                    halves++;
                    j   = 0;
                    per = 1;
                    cur_word = ((wclk_out == 1'b1) == (fmt[1] == 1'b0)) ? sh_l : sh_r;
                end else begin
                    j++;
                    per++;
                end
                if (seen_half) begin
                    exp_f = (j >= 1 && j <= W);
                    chk(fsync_out == exp_f, "R7", {31'd0, fsync_out}, {31'd0, exp_f});
                    exp_d = exp_f ? cur_word[W-j] : 1'b0;
                    tag = !exp_f ? "R9" : (j == 1 ? "R2" : (halves >= 3 ? "R10" : "R1"));
                    chk(sdata == exp_d, tag, {31'd0, sdata}, {31'd0, exp_d});
                end
            end
            prev_b = bclk_out;
            prev_w = wclk_out;
        end
    endtask

    task automatic do_load(input logic [W-1:0] l, input logic [W-1:0] r);
        lw = l; rw = r; load = 1'b1;
        sh_l = l; sh_r = r;
        step();
        load = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] f, input logic fast);
        mon_en = 1'b0;
        rst_n = 1'b0; fmt = f; speed_fast = fast; load = 1'b0;
        bclk_in = 1'b1; wclk_in = 1'b0; fsync_in = 1'b0;
        sh_l = '0; sh_r = '0;
        repeat (3) step();
        // R8: all driven pins low during reset
        chk({bclk_out, wclk_out, fsync_out, sdata} == 4'b0000, "R8",
            {28'd0, bclk_out, wclk_out, fsync_out, sdata}, 32'd0);
        // R2: pin direction follows fmt[0]
        chk({bclk_oe, wclk_oe, fsync_oe} == {3{f[0]}}, "R2",
            {29'd0, bclk_oe, wclk_oe, fsync_oe}, {29'd0, {3{f[0]}}});
        rst_n = 1'b1;
        step();
    endtask

    task automatic run_master(input logic [1:0] f, input logic fast);
        do_reset(f, fast);
        half_len = fast ? 32 : 64;
        prev_b = bclk_out; prev_w = wclk_out;
        seen_half = 1'b0; halves = 0; j = 0; per = 0;
        mon_en = 1'b1;
        do_load(24'hB4E21D, 24'h5A1C63);
        // R10: load in the middle of half 2, effective from half 3
        while (!(halves == 2 && j == 5)) step();
        do_load(24'h800001, 24'h7FFFFE);
        // R10: load sampled on the edge that opens half 4
        while (!(halves == 3 && j == half_len - 1 && bclk_out == 1'b1)) step();
        do_load(24'h3C0FF0, 24'hC3F00F);
        while (halves < 6) step();
        mon_en = 1'b0;
    endtask

    // one slave bit period: bit clock falls (with new word clock / strobe), rises, then sample
    task automatic sbit(input logic w, input logic f, input logic e, input string tag);
        bclk_in = 1'b0; wclk_in = w; fsync_in = f;
        repeat (4) step();
        bclk_in = 1'b1;
        repeat (4) step();
        chk(sdata === e, tag, {31'd0, sdata}, {31'd0, e});
    endtask

    task automatic shalf(input logic lvl, input int nbits, input int gp, input string tg);
        logic [W-1:0] wd;
        int           n;
        logic         f, e;
        string        t;
        wd = ((lvl == 1'b1) == (fmt[1] == 1'b0)) ? sh_l : sh_r;
        n  = 0;
        for (int jj = 0; jj < nbits; jj++) begin
            case (gp)
                1:       f = !(jj < 3 || (jj >= 10 && jj < 13));
                2:       f = (jj % 2 == 1);
                default: f = 1'b1;
            endcase
            if (fmt[1] == 1'b0) begin
                e = (n < W) ? wd[W-1-n] : 1'b0;
                t = (n >= W) ? "R9" : tg;
            end else begin
                e = (jj >= 1 && jj <= W) ? wd[W-jj] : 1'b0;
                t = (jj > W) ? "R9" : tg;
            end
            sbit(lvl, f, e, t);
            if (f) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // master, left on word clock low, 64 slots per half (R1 R2 R6 R7 R9 R10)
        run_master(2'b11, 1'b0);
        // master, left on word clock high, 32 slots per half
        run_master(2'b01, 1'b1);

        // slave framing 00 (R3 R5 R11)
        do_reset(2'b00, 1'b0);
        do_load(24'hB4E21D, 24'h5A1C63);
        shalf(1'b1, 32, 0, "R3");
        shalf(1'b0, 32, 0, "R2");
        shalf(1'b1, 32, 1, "R5");
        shalf(1'b0, 10, 0, "R11");
        shalf(1'b1, 32, 0, "R11");

        // slave framing 10 (R4)
        do_reset(2'b10, 1'b0);
        do_load(24'h800001, 24'h7FFFFE);
        shalf(1'b1, 32, 2, "R4");
        shalf(1'b0, 32, 2, "R4");
        shalf(1'b1, 32, 0, "R2");

        summary();
        $finish;
    end

endmodule